// File: doc/BRIEF.md
# Reset Source Supervisor

This block combines every reset request in the chip into one active-low system reset. It also keeps a sticky register that software reads to find out why the most recent reset happened. There are six sources: a shared external pin, power-on detect, brownout detect, the watchdog, a software request and a serial-line break detect. The comparator outputs for brownout arrive as digital signals that are already synchronized. One signal is provided for each trip level. A configuration code picks which level counts for the brownout reset, and a software register does the same for the brownout interrupt.

The system reset goes low in the same cycle that any internal source becomes active. It is released on a clock edge once every source has been quiet for a set number of cycles. The shared pin can act as a reset input or as a plain digital input. During power-up it always acts as a reset input. The power mode decides which brownout functions are gated. Two addresses on a small register port give software access: address 0 is the cause flags and address 1 is the brownout-interrupt configuration.

Top module: `rst_supervisor`

## Requirements
- R1: `sys_rst_n` is low, with no clock edge needed, in every cycle in which power-on detect, watchdog, software, break or the gated brownout request is active.
- R2: After the last cycle with an active source, `sys_rst_n` stays low for HOLD (4) more rising edges and goes high on the following edge.
- R3: A power-on or watchdog event loads the flags with the power-on bit (bit 1) and the brownout bit (bit 2) set. A watchdog event also sets its own bit (bit 3). Every other bit is cleared. Flag bits: 0 pin, 1 power-on, 2 brownout, 3 watchdog, 4 software, 5 break.
- R4: A pin, brownout, software or break event sets its own flag bit. All other flags keep their values.
- R5: A write to address 0 clears each flag whose write-data bit is 0 and leaves the flags whose bit is 1 unchanged. A flag set by an event in the same cycle survives the write.
- R6: The pin level passes through two synchronizer flops. With `pin_rst_en`=1, a low level resets the system. With `pin_rst_en`=0, a low level causes no reset and `pin_din` follows the pin.
- R7: After `rst` or a power-on event, and until the reset is next released, the pin acts as a reset input whatever `pin_rst_en` says. During that time `pin_din` reads 1.
- R8: The brownout reset uses the comparator chosen by `bod_rst_lvl`. It is active in `pwr_mode` 0 (run), 1 (idle) and 2 (power-down), and masked in mode 3 (total power-down).
- R9: `bod_irq` = enable (addr 1, bit 0) AND the comparator chosen by addr 1 bits 2:1. It is masked in mode 3.
- R10: `flash_prot` follows `bod_flash_below` in modes 0 and 1 and is 0 in modes 2 and 3.
- R11: A read of address 0 returns the flags. A read of address 1 returns {level, enable}, with the unused upper bits 0.
- R12: While `rst` is high: flags are 0, the interrupt configuration is 0, and `sys_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high initialisation |
| por_det | input | 1 | Power-on detect, active high |
| pin_raw | input | 1 | Shared pin level, asynchronous |
| pin_rst_en | input | 1 | 1: pin is an active-low reset input |
| wdt_req | input | 1 | Watchdog reset request |
| sw_req | input | 1 | Software reset request |
| brk_req | input | 1 | Serial break reset request |
| pwr_mode | input | 2 | 0 run, 1 idle, 2 power-down, 3 total power-down |
| bod_rst_lvl | input | 2 | Trip-level select for brownout reset |
| bod_rst_below | input | 4 | Supply-below flags for the reset trip levels |
| bod_int_below | input | 4 | Supply-below flags for the interrupt trip levels |
| bod_flash_below | input | 1 | Supply below the fixed flash-protect level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 flags, 1 interrupt configuration |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data for `reg_addr` |
| sys_rst_n | output | 1 | Active-low system reset |
| bod_irq | output | 1 | Brownout interrupt |
| flash_prot | output | 1 | Block flash programming |
| pin_din | output | 1 | Synchronized pin level when the pin is a digital input |

## Verification
Two things can happen in the same cycle: a software write that clears flags and a reset event that sets one. The bench forces this case directly, with a zero write on the same edge as a software request, and with a power-on and a break event together. It then checks that the newly set bit and the power-on pattern survive. The random phase draws writes and source pulses independently, so they overlap many times. After every edge a bench model of the priority rule (clear first, then reload on power-on or watchdog, then OR in the other events) supplies the expected flag word.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    localparam int NSRC = 6;

    typedef enum logic [2:0] {
        SRC_PIN = 3'd0,
        SRC_POR = 3'd1,
        SRC_BOD = 3'd2,
        SRC_WDT = 3'd3,
        SRC_SW  = 3'd4,
        SRC_BRK = 3'd5
    } src_e;

    typedef logic [NSRC-1:0] flags_t;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_PD   = 2'd2,
        PM_TPD  = 2'd3
    } pmode_e;

    // Next flag word: software clear first, then the power-on style reload,
    // then the sticky OR of the individual events.
    function automatic flags_t flag_next(flags_t cur, logic clr, flags_t keep, flags_t evt);
        flags_t f;
        f = cur;
        if (clr)
            f = f & keep;
        if (evt[SRC_POR] || evt[SRC_WDT]) begin
            f = '0;
            f[SRC_POR] = 1'b1;
            f[SRC_BOD] = 1'b1;
        end
        f = f | evt;
        f[SRC_POR] = f[SRC_POR] | evt[SRC_WDT];
        return f;
    endfunction

    function automatic logic mode_allows_bod(pmode_e m);
        return (m != PM_TPD);
    endfunction

    function automatic logic mode_allows_flash(pmode_e m);
        return (m == PM_RUN) || (m == PM_IDLE);
    endfunction

endpackage

// File: rtl/rsup_pin_sync.sv
module rsup_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    input  logic pin_rst_en,
    input  logic pwrup,
    output logic pin_rst,
    output logic pin_din
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= pin_raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], pin_raw};
            end
        end
    endgenerate

    logic as_reset;
    assign as_reset = pin_rst_en | pwrup;
    assign pin_rst  = as_reset & ~sh[STAGES-1];
    assign pin_din  = as_reset | sh[STAGES-1];
endmodule

// File: rtl/rsup_bod_gate.sv
module rsup_bod_gate
    import rsup_pkg::*;
#(
    parameter int LEVELS = 4,
    localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  pmode_e            mode,
    input  logic [LW-1:0]     rst_lvl,
    input  logic [LEVELS-1:0] rst_below,
    input  logic              int_en,
    input  logic [LW-1:0]     int_lvl,
    input  logic [LEVELS-1:0] int_below,
    input  logic              flash_below,
    output logic              bod_rst,
    output logic              bod_irq,
    output logic              flash_prot
);
    logic rst_hit, int_hit;

    always_comb begin
        rst_hit = 1'b0;
        int_hit = 1'b0;
        for (int i = 0; i < LEVELS; i++) begin
            if (rst_lvl == LW'(i)) rst_hit = rst_below[i];
            if (int_lvl == LW'(i)) int_hit = int_below[i];
        end
    end

    assign bod_rst    = rst_hit & mode_allows_bod(mode);
    assign bod_irq    = int_en & int_hit & mode_allows_bod(mode);
    assign flash_prot = flash_below & mode_allows_flash(mode);
endmodule

// File: rtl/rsup_flags.sv
module rsup_flags
    import rsup_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  flags_t keep,
    input  flags_t evt,
    output flags_t flags_q
);
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flag_next(flags_q, clr, keep, evt);
    end
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
    parameter int HOLD = 4,
    localparam int CW = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic src_any,
    output logic rel_q,
    output logic sys_rst_n
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || src_any) begin
            cnt   <= '0;
            rel_q <= 1'b0;
        end else if (!rel_q) begin
            if (cnt == CW'(HOLD - 1)) rel_q <= 1'b1;
            else                      cnt   <= cnt + 1'b1;
        end
    end

    assign sys_rst_n = rel_q & ~src_any;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsup_pkg::*;
#(
    parameter int LEVELS      = 4,
    parameter int HOLD        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int DW = NSRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_det,
    input  logic              pin_raw,
    input  logic              pin_rst_en,
    input  logic              wdt_req,
    input  logic              sw_req,
    input  logic              brk_req,
    input  logic [1:0]        pwr_mode,
    input  logic [LW-1:0]     bod_rst_lvl,
    input  logic [LEVELS-1:0] bod_rst_below,
    input  logic [LEVELS-1:0] bod_int_below,
    input  logic              bod_flash_below,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              sys_rst_n,
    output logic              bod_irq,
    output logic              flash_prot,
    output logic              pin_din
);
    typedef struct packed {
        logic [LW-1:0] lvl;
        logic          en;
    } icfg_t;

    icfg_t  icfg_q;
    logic   pwrup_q;
    logic   rel_q;
    logic   pin_rst;
    logic   bod_rst_act;
    flags_t evt;
    flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst)
            icfg_q <= '0;
        else if (reg_we && reg_addr)
            icfg_q <= icfg_t'(reg_wdata[LW:0]);
    end

    always_ff @(posedge clk) begin
        if (rst || por_det) pwrup_q <= 1'b1;
        else if (rel_q)     pwrup_q <= 1'b0;
    end

    rsup_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .pin_rst_en(pin_rst_en),
        .pwrup(pwrup_q), .pin_rst(pin_rst), .pin_din(pin_din)
    );

    rsup_bod_gate #(.LEVELS(LEVELS)) u_bod (
        .mode(pmode_e'(pwr_mode)), .rst_lvl(bod_rst_lvl), .rst_below(bod_rst_below),
        .int_en(icfg_q.en), .int_lvl(icfg_q.lvl), .int_below(bod_int_below),
        .flash_below(bod_flash_below), .bod_rst(bod_rst_act),
        .bod_irq(bod_irq), .flash_prot(flash_prot)
    );

    always_comb begin
        evt          = '0;
        evt[SRC_PIN] = pin_rst;
        evt[SRC_POR] = por_det;
        evt[SRC_BOD] = bod_rst_act;
        evt[SRC_WDT] = wdt_req;
        evt[SRC_SW]  = sw_req;
        evt[SRC_BRK] = brk_req;
    end

    rsup_flags u_flags (
        .clk(clk), .rst(rst), .clr(reg_we && !reg_addr),
        .keep(flags_t'(reg_wdata)), .evt(evt), .flags_q(flags_q)
    );

    rsup_stretch #(.HOLD(HOLD)) u_hold (
        .clk(clk), .rst(rst), .src_any(|evt), .rel_q(rel_q), .sys_rst_n(sys_rst_n)
    );

    assign reg_rdata = reg_addr ? DW'(icfg_q) : DW'(flags_q);
endmodule

// File: rtl/rsup_chk.sv
module rsup_chk
    import rsup_pkg::*;
#(
    parameter int HOLD = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       sys_rst_n,
    input logic       bod_irq,
    input logic       flash_prot,
    input logic [1:0] pwr_mode,
    input logic       reg_we,
    input logic       reg_addr,
    input flags_t     wdata,
    input flags_t     evt,
    input flags_t     flags
);
    localparam int QW = $clog2(HOLD + 2);
    logic [QW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst || (|evt))       quiet <= '0;
        else if (quiet != QW'(HOLD)) quiet <= quiet + 1'b1;
    end

    assert_src_forces_rst_R1: assert property (@(posedge clk) disable iff (rst)
        (evt[SRC_POR] || evt[SRC_WDT] || evt[SRC_SW] || evt[SRC_BRK] || evt[SRC_BOD]) |-> !sys_rst_n);

    assert_release_after_hold_R2: assert property (@(posedge clk) disable iff (rst)
        sys_rst_n |-> (quiet == QW'(HOLD)));

    assert_reload_pattern_R3: assert property (@(posedge clk) disable iff (rst)
        (evt[SRC_POR] || evt[SRC_WDT]) |=> (flags[SRC_POR] && flags[SRC_BOD]));

    assert_sticky_sw_R4: assert property (@(posedge clk) disable iff (rst)
        evt[SRC_SW] |=> flags[SRC_SW]);

    assert_sticky_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && !evt[SRC_POR] && !evt[SRC_WDT]) |=> ((flags & $past(flags)) == $past(flags)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_addr && evt == '0) |=> ((flags & ~$past(wdata)) == '0));

    assert_tpd_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd3) |-> !evt[SRC_BOD]);

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
        bod_irq |-> (pwr_mode != 2'd3));

    assert_flash_mode_R10: assert property (@(posedge clk) disable iff (rst)
        flash_prot |-> (pwr_mode[1] == 1'b0));
endmodule

bind rst_supervisor rsup_chk #(.HOLD(HOLD)) u_chk (
    .clk(clk), .rst(rst), .sys_rst_n(sys_rst_n), .bod_irq(bod_irq),
    .flash_prot(flash_prot), .pwr_mode(pwr_mode), .reg_we(reg_we),
    .reg_addr(reg_addr), .wdata(reg_wdata), .evt(evt), .flags(flags_q)
);

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1, por_det = 1'b0, pin_raw = 1'b0, pin_rst_en = 1'b0;
    logic       wdt_req = 1'b0, sw_req = 1'b0, brk_req = 1'b0;
    logic [1:0] pwr_mode = 2'd0, bod_rst_lvl = 2'd0;
    logic [3:0] bod_rst_below = 4'd0, bod_int_below = 4'd0;
    logic       bod_flash_below = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
    logic [5:0] reg_wdata = 6'd0;
    logic [5:0] reg_rdata;
    logic       sys_rst_n, bod_irq, flash_prot, pin_din;

    rst_supervisor u0 (
        .clk(clk), .rst(rst), .por_det(por_det), .pin_raw(pin_raw),
        .pin_rst_en(pin_rst_en), .wdt_req(wdt_req), .sw_req(sw_req),
        .brk_req(brk_req), .pwr_mode(pwr_mode), .bod_rst_lvl(bod_rst_lvl),
        .bod_rst_below(bod_rst_below), .bod_int_below(bod_int_below),
        .bod_flash_below(bod_flash_below), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n),
        .bod_irq(bod_irq), .flash_prot(flash_prot), .pin_din(pin_din)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Expected flags: clear, then reload on power-on/watchdog, then OR events.
    // Bits: 0 pin, 1 power-on, 2 brownout, 3 watchdog, 4 software, 5 break.
    function automatic logic [5:0] model(logic [5:0] cur, logic we, logic [5:0] wd,
                                         logic por, logic wdt, logic sw, logic brk);
        logic [5:0] f;
        f = we ? (cur & wd) : cur;
        if (por || wdt) f = 6'b000110;
        if (wdt) f[3] = 1'b1;
        if (sw)  f[4] = 1'b1;
        if (brk) f[5] = 1'b1;
        return f;
    endfunction

    task automatic wr(logic a, logic [5:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    initial begin
        logic [5:0] exp;
        process_init: begin end
        tick(); tick(); tick();
        // R12 during rst
        check("R12 rst_n", sys_rst_n, 0);
        check("R12 flags", reg_rdata, 0);
        reg_addr = 1'b1; #1;
        check("R12 icfg", reg_rdata, 0);
        reg_addr = 1'b0;
        // R7: pin low at power-up, enable 0, still resets
        rst = 1'b0;
        repeat (8) tick();
        check("R7 pin forced reset", sys_rst_n, 0);
        check("R7 pin flag", reg_rdata, 6'h01);
        check("R7 pin_din", pin_din, 1);
        pin_raw = 1'b1;
        repeat (5) tick();
        check("R2 still held", sys_rst_n, 0);
        tick();
        check("R2 released", sys_rst_n, 1);
        tick();
        // R6: enable 0 after power-up, pin is plain input
        pin_raw = 1'b0;
        repeat (4) tick();
        check("R6 no reset", sys_rst_n, 1);
        check("R6 pin_din", pin_din, 0);
        check("R6 flags unchanged", reg_rdata, 6'h01);
        wr(1'b0, 6'h00);
        check("R5 clear", reg_rdata, 6'h00);
        pin_raw = 1'b1; tick();
        pin_rst_en = 1'b1; pin_raw = 1'b0;
        tick(); tick();
        check("R6 pin reset", sys_rst_n, 0);
        tick();
        check("R4 pin flag", reg_rdata, 6'h01);
        pin_raw = 1'b1;
        repeat (8) tick();
        check("R6 released", sys_rst_n, 1);
        // R8 brownout level select and mode gating
        bod_rst_below = 4'b0100; bod_rst_lvl = 2'd1;
        tick();
        check("R8 other level", sys_rst_n, 1);
        bod_rst_lvl = 2'd2; #1;
        check("R1 bod immediate", sys_rst_n, 0);
        tick();
        check("R4 bod flag", reg_rdata, 6'h05);
        pwr_mode = 2'd3;
        repeat (5) tick();
        check("R8 tpd masked", sys_rst_n, 1);
        pwr_mode = 2'd2; #1;
        check("R8 pd active", sys_rst_n, 0);
        bod_rst_below = 4'd0; pwr_mode = 2'd0;
        repeat (6) tick();
        // R9/R11 interrupt config
        wr(1'b1, 6'b000101);
        reg_addr = 1'b1; #1;
        check("R11 icfg read", reg_rdata, 6'h05);
        bod_int_below = 4'b0100; #1;
        check("R9 irq", bod_irq, 1);
        wr(1'b1, 6'b000011); #1;
        check("R9 other level", bod_irq, 0);
        wr(1'b1, 6'b000101);
        pwr_mode = 2'd3; #1;
        check("R9 tpd masked", bod_irq, 0);
        pwr_mode = 2'd2; #1;
        check("R9 pd active", bod_irq, 1);
        wr(1'b1, 6'b000100); #1;
        check("R9 disabled", bod_irq, 0);
        bod_int_below = 4'd0; pwr_mode = 2'd0; reg_addr = 1'b0;
        // R10 flash protect
        bod_flash_below = 1'b1;
        for (int m = 0; m < 4; m++) begin
            pwr_mode = 2'(m); #1;
            check("R10 flash", flash_prot, (m < 2) ? 1 : 0);
        end
        bod_flash_below = 1'b0; pwr_mode = 2'd0;
        tick();
        // R3/R4 flag rules
        exp = reg_rdata;
        check("R4 prior flags", exp, 6'h05);
        wdt_req = 1'b1; tick(); wdt_req = 1'b0;
        check("R3 wdt", reg_rdata, 6'h0E);
        sw_req = 1'b1; #1;
        check("R1 sw immediate", sys_rst_n, 0);
        tick(); sw_req = 1'b0;
        check("R4 sw", reg_rdata, 6'h1E);
        brk_req = 1'b1; tick(); brk_req = 1'b0;
        check("R4 brk", reg_rdata, 6'h3E);
        por_det = 1'b1; tick(); por_det = 1'b0;
        check("R3 por", reg_rdata, 6'h06);
        // R5 same-cycle clear and set
        reg_wdata = 6'h00; reg_we = 1'b1; sw_req = 1'b1;
        tick(); reg_we = 1'b0; sw_req = 1'b0;
        check("R5 set wins", reg_rdata, 6'h10);
        por_det = 1'b1; brk_req = 1'b1;
        tick(); por_det = 1'b0; brk_req = 1'b0;
        check("R3 por+brk", reg_rdata, 6'h26);
        exp = 6'h26;
        // random phase, fixed seed
        void'($urandom(32'h5eed));
        for (int i = 0; i < 400; i++) begin
            logic w, p, d, s, b;
            logic [5:0] wd;
            w = ($urandom % 4) == 0;
            p = ($urandom % 16) == 0;
            d = ($urandom % 16) == 0;
            s = ($urandom % 8) == 0;
            b = ($urandom % 8) == 0;
            wd = 6'($urandom);
            reg_we = w; reg_wdata = wd; por_det = p; wdt_req = d; sw_req = s; brk_req = b;
            tick();
            reg_we = 1'b0; por_det = 1'b0; wdt_req = 1'b0; sw_req = 1'b0; brk_req = 1'b0;
            exp = model(exp, w, wd, p, d, s, b);
            check("R3/R4/R5 random flags", reg_rdata, exp);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule